// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands. Each operand has a sign bit, an 8-bit biased exponent and a 23-bit fraction. The product is rounded to nearest, with ties going to even, and comes back in the same format.

The operation is a two-stage pipeline. The first stage forms the sign, the unnormalized exponent and the full 48-bit significand product; the hidden one is restored on both operands. The second stage does the following:

- normalizes the product by at most one position;
- rounds, using the bit just below the kept field and an OR of everything below that;
- renormalizes when rounding carries out;
- clamps the result to a signed infinity or a signed zero when the exponent leaves range.

A new operation may enter every cycle. Its result appears two cycles later with `out_valid` high.

Operands whose exponent field is zero count as zero. The block has no handling for values that are not numbers, and no special case for infinite inputs.

Top module: `fp32_mul`

## Requirements
- R1: The sign bit of the result (bit 31) is the XOR of the sign bits of the two operands, for every result including zero, infinity and clamped results.
- R2: For in-range results, the result exponent field (bits 30:23) equals the sum of the two operand exponent fields minus 127, plus one for each normalizing or renormalizing shift. A normal result never carries an all-ones exponent.
- R3: The 24-bit significand product (hidden one included) lies in [1,4). When it is 2 or more, the significand is shifted right by one before rounding and the exponent gains one. Otherwise no shift occurs, and the bit below the top integer bit becomes part of the result.
- R4: Rounding goes up when the discarded part of the significand is more than half a unit in the last place, and down when it is less.
- R5: When the discarded part is exactly half a unit in the last place, the result is whichever neighbour has a 0 in its least significant fraction bit.
- R6: If rounding makes the significand reach 2.0, the result is shifted right once more and the exponent is incremented again. The fraction field then becomes zero.
- R7: If the final biased exponent is 255 or more, `ovf` is 1 and `unf` is 0. The result is then exponent field all ones with a zero fraction (a signed infinity).
- R8: If the final biased exponent is 0 or less, `unf` is 1 and `ovf` is 0. The result is then exponent and fraction all zero (a signed zero).
- R9: If either operand has an exponent field of 0, the result is a zero carrying the XOR sign, and both `ovf` and `unf` are 0. This holds whatever the fraction bits are.
- R10: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` was high. Back-to-back inputs yield back-to-back results. `ovf` and `unf` are only ever high together with `out_valid`. After reset, `out_valid`, `result`, `ovf` and `unf` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands `a` and `b` are accepted this cycle |
| a | input | 32 | First operand: sign, 8-bit biased exponent, 23-bit fraction |
| b | input | 32 | Second operand, same format |
| out_valid | output | 1 | `result` and flags belong to the operation accepted two cycles earlier |
| result | output | 32 | Rounded product in the operand format |
| ovf | output | 1 | Product exponent too large; `result` is a signed infinity |
| unf | output | 1 | Product exponent too small; `result` is a signed zero |

## Verification
A wrong normalize decision shows up on the very next result as an exponent off by one and a fraction shifted by one bit. A fault in the rounding increment or tie detection affects only the fraction's low bits, and only for operands whose discarded bits land at or near the half point. For that reason the stimulus mixes random fractions with directed exact-tie and all-ones-carry cases.

A stale pipeline register appears as a result or valid pulse that belongs to the wrong cycle. Back-to-back issue exposes it within two cycles of the input that should have produced it.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [EW+FW:0]  a,
  input  logic [EW+FW:0]  b,
  output logic            out_valid,
  output logic [EW+FW:0]  result,
  output logic            ovf,
  output logic            unf
);
  localparam int W    = EW + FW + 1;
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 3;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;

  // stage 1: sign, exponent sum, raw significand product
  logic                 p_vld, p_sign, p_zero;
  logic signed [XW-1:0] p_exp;
  logic [PW-1:0]        p_prod;

  wire [EW-1:0] ea = a[W-2:FW];
  wire [EW-1:0] eb = b[W-2:FW];
  wire [MW-1:0] ma = {1'b1, a[FW-1:0]};
  wire [MW-1:0] mb = {1'b1, b[FW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld  <= 1'b0;
      p_sign <= 1'b0;
      p_zero <= 1'b0;
      p_exp  <= '0;
      p_prod <= '0;
    end else begin
      p_vld <= in_valid;
      if (in_valid) begin
        p_sign <= a[W-1] ^ b[W-1];
        p_zero <= (ea == '0) || (eb == '0);
        p_exp  <= $signed(XW'(ea)) + $signed(XW'(eb)) - $signed(XW'(BIAS));
        p_prod <= PW'(ma) * PW'(mb);
      end
    end
  end

  // stage 2: normalize, round to nearest even, renormalize, clamp
  wire top = p_prod[PW-1];

  logic [MW-1:0] keep;
  logic          rbit, sbit;

  always_comb begin
    if (top) begin
      keep = p_prod[PW-1:MW];
      rbit = p_prod[MW-1];
      sbit = |p_prod[MW-2:0];
    end else begin
      keep = p_prod[PW-2:MW-1];
      rbit = p_prod[MW-2];
      sbit = |p_prod[MW-3:0];
    end
  end

  wire          inc   = rbit & (sbit | keep[0]);
  wire [MW:0]   sum   = {1'b0, keep} + (MW+1)'(inc);
  wire          carry = sum[MW];
  wire [FW-1:0] frac  = carry ? sum[FW:1] : sum[FW-1:0];

  wire signed [XW-1:0] e_fin = p_exp + $signed(XW'(top)) + $signed(XW'(carry));
  wire big  = e_fin >= $signed(XW'(EMAX));
  wire tiny = e_fin <= $signed(XW'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= p_vld;
      ovf       <= p_vld & ~p_zero & big;
      unf       <= p_vld & ~p_zero & tiny;
      if (p_vld) begin
        if (p_zero || tiny)
          result <= {p_sign, {(W-1){1'b0}}};
        else if (big)
          result <= {p_sign, {EW{1'b1}}, {FW{1'b0}}};
        else
          result <= {p_sign, e_fin[EW-1:0], frac};
      end
    end
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [EW+FW:0] a,
  input logic [EW+FW:0] b,
  input logic           out_valid,
  input logic [EW+FW:0] result,
  input logic           ovf,
  input logic           unf
);
  localparam int W = EW + FW + 1;

  logic v1, v2, sg1, sg2, z1, z2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, sg1, sg2, z1, z2} <= '0;
    end else begin
      v1  <= in_valid;
      v2  <= v1;
      sg1 <= a[W-1] ^ b[W-1];
      sg2 <= sg1;
      z1  <= (a[W-2:FW] == '0) || (b[W-2:FW] == '0);
      z2  <= z1;
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2);
  p_flag_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || unf) |-> out_valid);
  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> result[W-1] == sg2);
  p_zero_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && z2) |-> (result[W-2:0] == '0 && !ovf && !unf));
  p_ovf_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result[W-2:FW] == '1 && result[FW-1:0] == '0 && !unf));
  p_unf_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (result[W-2:0] == '0 && !ovf));
  p_exp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ovf) |-> result[W-2:FW] != '1);
endmodule

bind fp32_mul fp32_mul_chk #(.EW(EW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
  .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf)
);

// File: tb/tb_fp32_mul.sv
module tb_fp32_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        out_valid, ovf, unf;
  logic [31:0] result;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  fp32_mul dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
                .out_valid(out_valid), .result(result), .ovf(ovf), .unf(unf));

  always #5 clk = ~clk;

  // expected {ovf, unf, result}, from the arithmetic definition
  function automatic logic [33:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    logic s;
    int e, sh;
    longint unsigned p, kept, rem, half;
    s = x[31] ^ y[31];
    if (x[30:23] == 0 || y[30:23] == 0) return {2'b00, s, 31'b0};
    p = 64'({1'b1, x[22:0]}) * 64'({1'b1, y[22:0]});
    e = int'(x[30:23]) + int'(y[30:23]) - 127;
    sh = (p >= (64'd1 << 47)) ? 24 : 23;
    if (sh == 24) e++;
    kept = p >> sh;
    rem  = p & ((64'd1 << sh) - 1);
    half = 64'd1 << (sh - 1);
    if (rem > half || (rem == half && kept[0])) kept++;
    if (kept == (64'd1 << 24)) begin kept >>= 1; e++; end
    if (e >= 255) return {2'b10, s, 8'hff, 23'b0};
    if (e <= 0)   return {2'b01, s, 31'b0};
    return {2'b00, s, e[7:0], kept[22:0]};
  endfunction

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input string req);
    @(negedge clk);
    a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 valid low one cycle after issue", 34'(out_valid), 34'(0));
    @(negedge clk);
    check("R10 valid two cycles after issue", 34'(out_valid), 34'(1));
    check(req, {ovf, unf, result}, ref_mul(x, y));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] qa [10];
    logic [31:0] qb [10];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R10 reset state", {ovf, unf, result}, 34'(0));
    check("R10 reset valid", 34'(out_valid), 34'(0));
    rst_n = 1'b1;

    run(32'h3F800000, 32'h3F800000, "R2 one times one");
    check("R2 one times one exact", 34'(result), 34'h3F800000);
    run(32'h83C00000, 32'h70400000, "R3 normalize shift, mixed signs");
    check("R3 normalize exact", 34'(result), 34'hB4900000);
    run(32'hBFC00000, 32'hBFC00000, "R1 neg times neg");
    run(32'h3F800001, 32'h3FC00000, "R5 tie rounds up to even");
    check("R5 tie up exact", 34'(result), 34'h3FC00002);
    run(32'h3F800003, 32'h3FC00000, "R5 tie rounds down to even");
    check("R5 tie down exact", 34'(result), 34'h3FC00004);
    run(32'h3FFFFFFF, 32'h3F7FFFFF, "R4 above half rounds up");
    run(32'h3F800001, 32'h3FFFFFFE, "R6 rounding carry renormalizes");
    check("R6 renormalize exact", 34'(result), 34'h40000000);
    run(32'h7F000000, 32'h3F800000, "R2 largest exponent in range");
    run(32'h7F000000, 32'h40000000, "R7 overflow positive");
    check("R7 overflow exact", {ovf, unf, result}, {2'b10, 32'h7F800000});
    run(32'hFF000000, 32'h40000000, "R7 overflow negative");
    run(32'h00800000, 32'h3F000000, "R8 underflow to zero");
    check("R8 underflow exact", {ovf, unf, result}, {2'b01, 32'h00000000});
    run(32'h80800000, 32'h3F000000, "R8 underflow negative");
    run(32'h00800000, 32'h3F800000, "R8 smallest normal stays");
    run(32'h00000000, 32'h40000000, "R9 zero operand");
    run(32'h80000000, 32'h3F800000, "R9 negative zero");
    run(32'h00400000, 32'h7F000000, "R9 zero exponent, nonzero fraction");
    check("R9 no flags", {ovf, unf, result}, {2'b00, 32'h80000000 & 32'h0});

    for (int i = 0; i < 300; i++) begin
      logic [31:0] x, y;
      x = $urandom; y = $urandom;
      if (i % 3 != 0) begin
        x[30:23] = 8'(100 + $urandom_range(0, 54));
        y[30:23] = 8'(100 + $urandom_range(0, 54));
      end
      run(x, y, "R4 random operands");
    end

    for (int i = 0; i < 10; i++) begin
      qa[i] = $urandom; qb[i] = $urandom;
      qa[i][30:23] = 8'(110 + $urandom_range(0, 34));
      qb[i][30:23] = 8'(110 + $urandom_range(0, 34));
    end
    qa[4] = 32'h7F000000; qb[4] = 32'h40000000;
    qa[6] = 32'h00000000; qb[6] = 32'h3F800000;
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      if (k >= 2 && k < 12) begin
        check("R10 back-to-back valid", 34'(out_valid), 34'(1));
        check("R10 back-to-back result", {ovf, unf, result}, ref_mul(qa[k-2], qb[k-2]));
      end
      if (k == 12) check("R10 valid drops after burst", 34'(out_valid), 34'(0));
      if (k < 10) begin
        a = qa[k]; b = qb[k]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0;
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule